// File: doc/BRIEF.md
# Byte-Lane Memory Access Steering

This block sits between a 16-bit CPU datapath and a memory organised as two byte lanes, each with its own active-low enable. From the active-low read strobe, address bit 0 and the word/byte flag of the current instruction, it produces the upper and lower lane enables for the memory. On reads it also shapes the data returned to the CPU: an odd-byte read brings the upper memory byte down into the low lane, so software always finds the requested byte in bits 7..0.

The logic is purely combinational. Write data passes the block by; software places a byte to be stored in both halves of the word, and the enables pick which half memory accepts. Clearing or sign-filling the unused half of a byte read is left to software. The lower enable is wired straight from address bit 0, so an even-byte read is served as a full word read.

Top module: `byte_lane_steer`

## Requirements
- R1: `lane_lo_en_no` equals `addr0_i` for every combination of inputs (0 = lower lane enabled).
- R2: During a read (`rd_ni` = 0) `lane_hi_en_no` is 0, whatever `addr0_i` and `word_i` are.
- R3: A read with `addr0_i` = 0 returns `mem_rdata_i` unchanged on `cpu_rdata_o`.
- R4: A read with `addr0_i` = 1 places `mem_rdata_i[15:8]` on `cpu_rdata_o[7:0]`.
- R5: A read with `addr0_i` = 1 keeps `mem_rdata_i[15:8]` on `cpu_rdata_o[15:8]`.
- R6: A word write (`rd_ni` = 1, `word_i` = 1) drives `lane_hi_en_no` = 0; with `addr0_i` = 0 both lanes are enabled.
- R7: A byte write (`rd_ni` = 1, `word_i` = 0) with `addr0_i` = 0 drives `lane_hi_en_no` = 1 and `lane_lo_en_no` = 0.
- R8: A byte write with `addr0_i` = 1 drives `lane_hi_en_no` = 0 and `lane_lo_en_no` = 1.
- R9: While no read is active (`rd_ni` = 1) `cpu_rdata_o` equals `mem_rdata_i`; no lane is moved.
- R10: `word_i` has no effect on either enable or on `cpu_rdata_o` during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_ni | input | 1 | Read strobe, active low |
| addr0_i | input | 1 | Address bit 0, selects odd byte when 1 |
| word_i | input | 1 | 1 = word access, 0 = byte access |
| mem_rdata_i | input | 16 | Data from memory |
| lane_hi_en_no | output | 1 | Upper byte lane enable, active low |
| lane_lo_en_no | output | 1 | Lower byte lane enable, active low |
| cpu_rdata_o | output | 16 | Read data presented to the CPU |

## Verification
The case hardest to expose is an odd-byte read whose two memory bytes are equal or whose upper byte repeats the lower, since a missing lane move then looks correct. The bench therefore applies data patterns whose two bytes differ in every bit as well as patterns with a single set bit in each lane, and walks all eight strobe/address/width combinations for each pattern, so a swapped, dropped or duplicated lane shows on the ports. The ignored width flag on reads is checked by presenting both values of `word_i` with identical data and comparing all three outputs.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int unsigned LANE_W  = 8;
  localparam int unsigned N_LANES = 2;
  localparam int unsigned DATA_W  = LANE_W * N_LANES;

  typedef enum logic [1:0] {
    ACC_READ       = 2'd0,
    ACC_WR_WORD    = 2'd1,
    ACC_WR_BYTE_LO = 2'd2,
    ACC_WR_BYTE_HI = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/bl_classify.sv
module bl_classify
  import bl_pkg::*;
(
  input  logic      rd_ni,
  input  logic      addr0_i,
  input  logic      word_i,
  output acc_kind_e kind_o
);
  always_comb begin
    if (!rd_ni)       kind_o = ACC_READ;
    else if (word_i)  kind_o = ACC_WR_WORD;
    else if (addr0_i) kind_o = ACC_WR_BYTE_HI;
    else              kind_o = ACC_WR_BYTE_LO;
  end
endmodule

// File: rtl/bl_lane_enable.sv
module bl_lane_enable
  import bl_pkg::*;
(
  input  acc_kind_e kind_i,
  input  logic      addr0_i,
  output logic      hi_en_no,
  output logic      lo_en_no
);
  // lower lane tracks A0 directly
  assign lo_en_no = addr0_i;
  assign hi_en_no = (kind_i == ACC_WR_BYTE_LO);

  always_comb begin
    if (kind_i == ACC_WR_BYTE_HI) AST_HI_BYTE_WR: assert (!hi_en_no && lo_en_no); // R8
    if (kind_i == ACC_READ)       AST_RD_HI_ON:   assert (!hi_en_no);             // R2
  end
endmodule

// File: rtl/bl_rd_steer.sv
module bl_rd_steer
  import bl_pkg::*;
#(
  parameter int unsigned LW = LANE_W,
  parameter int unsigned NL = N_LANES
) (
  input  acc_kind_e         kind_i,
  input  logic              addr0_i,
  input  logic [LW*NL-1:0]  mem_i,
  output logic [LW*NL-1:0]  cpu_o
);
  localparam int unsigned TOP = NL - 1;

  logic move_down;
  assign move_down = (kind_i == ACC_READ) && addr0_i;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign cpu_o[LW-1:0] = move_down ? mem_i[TOP*LW +: LW] : mem_i[LW-1:0];
    end else begin : g_pass
      assign cpu_o[g*LW +: LW] = mem_i[g*LW +: LW];
    end
  end

  always_comb begin
    if (move_down)  AST_ODD_LOW:  assert (cpu_o[LW-1:0] == mem_i[TOP*LW +: LW]); // R4
    if (!move_down) AST_NO_MOVE:  assert (cpu_o == mem_i);                        // R9
  end
endmodule

// File: rtl/byte_lane_steer.sv
module byte_lane_steer
  import bl_pkg::*;
(
  input  logic              rd_ni,
  input  logic              addr0_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              lane_hi_en_no,
  output logic              lane_lo_en_no,
  output logic [DATA_W-1:0] cpu_rdata_o
);
  acc_kind_e kind;

  bl_classify u_cls (
    .rd_ni   (rd_ni),
    .addr0_i (addr0_i),
    .word_i  (word_i),
    .kind_o  (kind)
  );

  bl_lane_enable u_en (
    .kind_i   (kind),
    .addr0_i  (addr0_i),
    .hi_en_no (lane_hi_en_no),
    .lo_en_no (lane_lo_en_no)
  );

  bl_rd_steer u_rd (
    .kind_i  (kind),
    .addr0_i (addr0_i),
    .mem_i   (mem_rdata_i),
    .cpu_o   (cpu_rdata_o)
  );

  always_comb begin
    AST_LO_FOLLOWS_A0: assert (lane_lo_en_no == addr0_i); // R1
    if (!rd_ni && !addr0_i) AST_EVEN_RD_WORD: assert (cpu_rdata_o == mem_rdata_i); // R3
    if (!rd_ni && addr0_i)
      AST_ODD_HI_KEPT: assert (cpu_rdata_o[DATA_W-1 -: LANE_W] == mem_rdata_i[DATA_W-1 -: LANE_W]); // R5
    if (rd_ni && word_i) AST_WORD_WR_HI: assert (!lane_hi_en_no); // R6
    if (rd_ni && !word_i && !addr0_i)
      AST_LO_BYTE_WR: assert (lane_hi_en_no && !lane_lo_en_no); // R7
    if (!rd_ni) AST_RD_WIDTH_IGN: assert (kind == ACC_READ); // R10
  end
endmodule

// File: tb/sim_byte_lane_steer.sv
module sim_byte_lane_steer;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rd_ni, addr0_i, word_i;
  logic [15:0] mem_rdata_i, cpu_rdata_o;
  logic lane_hi_en_no, lane_lo_en_no;
  int total = 0, bad = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  byte_lane_steer u0 (
    .rd_ni(rd_ni), .addr0_i(addr0_i), .word_i(word_i), .mem_rdata_i(mem_rdata_i),
    .lane_hi_en_no(lane_hi_en_no), .lane_lo_en_no(lane_lo_en_no), .cpu_rdata_o(cpu_rdata_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (rd_n=%b a0=%b w=%b d=%h)",
               req, act, exp, rd_ni, addr0_i, word_i, mem_rdata_i);
    end
  endtask

  task automatic apply(input logic r, input logic a, input logic w, input logic [15:0] d);
    @(negedge clk);
    rd_ni = r; addr0_i = a; word_i = w; mem_rdata_i = d;
    #2;
  endtask

  // reference model from the requirements
  task automatic check_combo(input logic r, input logic a, input logic w, input logic [15:0] d);
    logic [15:0] exp_d;
    logic exp_hi;
    apply(r, a, w, d);
    chk("R1", {15'd0, lane_lo_en_no}, {15'd0, a});
    if (!r) begin
      chk("R2", {15'd0, lane_hi_en_no}, 16'd0);
      if (!a) chk("R3", cpu_rdata_o, d);
      else begin
        chk("R4", {8'd0, cpu_rdata_o[7:0]}, {8'd0, d[15:8]});
        chk("R5", {8'd0, cpu_rdata_o[15:8]}, {8'd0, d[15:8]});
      end
    end else begin
      exp_hi = (!w && !a);
      if (w)       chk("R6", {15'd0, lane_hi_en_no}, 16'd0);
      else if (!a) chk("R7", {14'd0, lane_hi_en_no, lane_lo_en_no}, 16'b10);
      else         chk("R8", {14'd0, lane_hi_en_no, lane_lo_en_no}, 16'b01);
      chk("R9", cpu_rdata_o, d);
      exp_d = d;
      chk("R6", {15'd0, lane_hi_en_no}, {15'd0, exp_hi});
    end
  endtask

  task automatic t_reset_state;
    apply(1'b1, 1'b0, 1'b1, 16'h0000);
    chk("R6", {14'd0, lane_hi_en_no, lane_lo_en_no}, 16'b00);
    chk("R9", cpu_rdata_o, 16'h0000);
  endtask

  task automatic t_exhaustive(input logic [15:0] d);
    for (int i = 0; i < 8; i++) check_combo(i[2], i[1], i[0], d);
  endtask

  task automatic t_width_ignored_on_read(input logic [15:0] d);
    logic [15:0] q0; logic h0, l0;
    for (int a = 0; a < 2; a++) begin
      apply(1'b0, a[0], 1'b0, d);
      q0 = cpu_rdata_o; h0 = lane_hi_en_no; l0 = lane_lo_en_no;
      apply(1'b0, a[0], 1'b1, d);
      chk("R10", cpu_rdata_o, q0);
      chk("R10", {14'd0, lane_hi_en_no, lane_lo_en_no}, {14'd0, h0, l0});
    end
  endtask

  initial begin
    rd_ni = 1'b1; addr0_i = 1'b0; word_i = 1'b1; mem_rdata_i = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    t_reset_state();
    t_exhaustive(16'hA55A);
    t_exhaustive(16'h00FF);
    t_exhaustive(16'hFF00);
    t_exhaustive(16'h8001);
    t_exhaustive(16'h1234);
    t_width_ignored_on_read(16'hC33C);
    t_width_ignored_on_read(16'h7E01);
    done = 1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp<=5000", cycles);
      done = 1;
    end
  end

  initial begin
    wait (done);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule